// File: doc/BRIEF.md
# Split-Word Increment Update Bridge

This block stages a 24-bit sub-second increment for a real-time counter that runs on its own clock. Software writes the low 16 bits and the high 8 bits into two bus-side staging registers. It then sets an update request bit in a control register. The request crosses into the counter domain through a synchronizer. On the rising edge of the synchronized request, the counter side captures all 24 bits at once and emits a one-cycle load strobe.

The counter side answers with an acknowledge level. That level returns through a second synchronizer and can be read in the control register. Software clears the request after it reads the acknowledge as 1, and the acknowledge then falls, which completes a four-phase handshake. While the request and the acknowledge differ, the staging registers and the request bit are frozen, so the value being carried cannot tear.

Top module: `upd_bridge`

## Requirements
- R1: After reset, every register reads 0, `inc_value` is 0, and both `inc_load` and `upd_ack_o` are 0.
- R2: The bus uses word addresses. Address 0 holds the low staging field in bits 15:0. Address 1 holds the high staging field in bits 7:0. Address 2 is control, with the request at bit 0 (read-write) and the acknowledge at bit 1 (read-only). Address 3 and all unused bits read 0, and a write keeps only the field bits.
- R3: While the request differs from the synchronized acknowledge, writes to both staging registers are ignored. When the two are equal, such writes take effect.
- R4: The request bit changes only through a control write made while it equals the acknowledge. A control write made while they differ is ignored. Writing bit 1 has no effect.
- R5: On each rising edge of the synchronized request, the counter side loads the 24-bit value {high, low} as one word and pulses `inc_load` for one counter clock, in the same cycle that `inc_value` changes. `inc_value` changes at no other time.
- R6: The acknowledge rises only after the counter side has captured the value. After software clears the request, the acknowledge falls, and a new update can then be started.
- R7: Each request produces exactly one load. Holding the request high, or changing the staged value after the acknowledge, causes no further load.
- R8: `upd_ack_o` always equals the acknowledge bit that the control register reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus-side clock |
| rst_bus_n | input | 1 | Bus-side asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for one bus cycle |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| upd_ack_o | output | 1 | Synchronized acknowledge (status) |
| clk_rtc | input | 1 | Counter-domain clock |
| rst_rtc_n | input | 1 | Counter-domain asynchronous reset, active low |
| inc_value | output | 24 | Increment value captured in the counter domain |
| inc_load | output | 1 | One-cycle strobe marking a new `inc_value` |

## Verification
The bench targets the window after the request is set and before the acknowledge returns. In that window it writes new staging data and tries to clear the request. A design that tears the transfer would show the late data in the loaded value, and one that drops a handshake phase would show the request falling early. It also runs all-ones, all-zeros and alternating-bit values, so that a swapped or truncated half-word shows up in the scoreboard. After each acknowledge it holds the request high and rewrites the staging data. This exposes a design that loads on the level rather than on the edge, because that design would produce extra loads or change the value without a request.

// File: rtl/upd_bridge_pkg.sv
package upd_bridge_pkg;

    typedef enum logic [1:0] {
        REG_INC_LO = 2'd0,
        REG_INC_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam int CTRL_REQ_BIT    = 0;
    localparam int CTRL_ACK_BIT    = 1;
    localparam int SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/upd_stage_regs.sv
module upd_stage_regs
    import upd_bridge_pkg::*;
#(
    parameter int LO_W   = 16,
    parameter int HI_W   = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_sync,
    output logic [DATA_W-1:0] rdata,
    output logic [LO_W-1:0]   stage_lo,
    output logic [HI_W-1:0]   stage_hi,
    output logic              req
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        logic            req;
    } regs_t;

    regs_t st_d, st_q;
    logic  idle;
    logic  unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:LO_W];

    always_comb begin
        st_d = st_q;
        idle = (st_q.req == ack_sync);
        if (wr_en && idle) begin
            unique case (reg_sel_e'(addr))
                REG_INC_LO: st_d.lo  = wdata[LO_W-1:0];
                REG_INC_HI: st_d.hi  = wdata[HI_W-1:0];
                REG_CTRL:   st_d.req = wdata[CTRL_REQ_BIT];
                default:    st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_INC_LO: rdata = DATA_W'(st_q.lo);
            REG_INC_HI: rdata = DATA_W'(st_q.hi);
            REG_CTRL:   rdata = DATA_W'({ack_sync, st_q.req});
            default:    rdata = '0;
        endcase
    end

    assign stage_lo = st_q.lo;
    assign stage_hi = st_q.hi;
    assign req      = st_q.req;
endmodule

// File: rtl/upd_capture.sv
module upd_capture #(
    parameter int VAL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic [VAL_W-1:0] stage_val,
    output logic [VAL_W-1:0] value,
    output logic             load,
    output logic             ack
);
    typedef struct packed {
        logic             req_seen;
        logic [VAL_W-1:0] val;
        logic             load;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.req_seen = req_sync;
        st_d.load     = req_sync & ~st_q.req_seen;
        if (st_d.load) st_d.val = stage_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;
    assign load  = st_q.load;
    assign ack   = st_q.req_seen;
endmodule

// File: rtl/upd_bridge.sv
module upd_bridge #(
    parameter int LO_W        = 16,
    parameter int HI_W        = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = upd_bridge_pkg::SYNC_STAGES_DEF
) (
    input  logic                   clk_bus,
    input  logic                   rst_bus_n,
    input  logic                   bus_wr_en,
    input  logic [1:0]             bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   upd_ack_o,
    input  logic                   clk_rtc,
    input  logic                   rst_rtc_n,
    output logic [LO_W+HI_W-1:0]   inc_value,
    output logic                   inc_load
);
    localparam int VAL_W = LO_W + HI_W;

    logic [LO_W-1:0] stage_lo;
    logic [HI_W-1:0] stage_hi;
    logic            upd_req;
    logic            req_rtc_sync;
    logic            rtc_ack;
    logic            ack_bus_sync;

    upd_stage_regs #(.LO_W(LO_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk_bus),
        .rst_n    (rst_bus_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ack_sync (ack_bus_sync),
        .rdata    (bus_rdata),
        .stage_lo (stage_lo),
        .stage_hi (stage_hi),
        .req      (upd_req)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk_rtc),
        .rst_n (rst_rtc_n),
        .d     (upd_req),
        .q     (req_rtc_sync)
    );

    upd_capture #(.VAL_W(VAL_W)) u_cap (
        .clk       (clk_rtc),
        .rst_n     (rst_rtc_n),
        .req_sync  (req_rtc_sync),
        .stage_val ({stage_hi, stage_lo}),
        .value     (inc_value),
        .load      (inc_load),
        .ack       (rtc_ack)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk_bus),
        .rst_n (rst_bus_n),
        .d     (rtc_ack),
        .q     (ack_bus_sync)
    );

    assign upd_ack_o = ack_bus_sync;
endmodule

// File: rtl/upd_bridge_chk.sv
module upd_bridge_chk #(
    parameter int LO_W = 16,
    parameter int HI_W = 8
) (
    input logic                 clk_bus,
    input logic                 rst_bus_n,
    input logic                 clk_rtc,
    input logic                 rst_rtc_n,
    input logic                 req,
    input logic                 ack_sync,
    input logic [LO_W-1:0]      stage_lo,
    input logic [HI_W-1:0]      stage_hi,
    input logic [LO_W+HI_W-1:0] inc_value,
    input logic                 inc_load,
    input logic                 rtc_ack
);
    p_stage_frozen_r3: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (req != ack_sync) |=> $stable({stage_hi, stage_lo}));

    p_req_gated_r4: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (req != $past(req)) |-> ($past(req) == $past(ack_sync)));

    p_value_on_load_r5: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        !$stable(inc_value) |-> inc_load);

    p_ack_needs_req_r6: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $rose(ack_sync) |-> req);

    p_ack_after_load_r6: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        $rose(rtc_ack) |-> inc_load);

    p_single_load_r7: assert property (@(posedge clk_rtc) disable iff (!rst_rtc_n)
        inc_load |=> !inc_load);
endmodule

bind upd_bridge upd_bridge_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk_bus   (clk_bus),
    .rst_bus_n (rst_bus_n),
    .clk_rtc   (clk_rtc),
    .rst_rtc_n (rst_rtc_n),
    .req       (upd_req),
    .ack_sync  (ack_bus_sync),
    .stage_lo  (stage_lo),
    .stage_hi  (stage_hi),
    .inc_value (inc_value),
    .inc_load  (inc_load),
    .rtc_ack   (rtc_ack)
);

// File: tb/tb_upd_bridge.sv
`timescale 1ns/1ps
module tb_upd_bridge;
    logic        clk_bus = 1'b0;
    logic        clk_rtc = 1'b0;
    logic        rst_bus_n = 1'b0;
    logic        rst_rtc_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        upd_ack_o;
    logic [23:0] inc_value;
    logic        inc_load;

    int vectors = 0;
    int miscompares = 0;
    int loads = 0;
    int bus_cycles = 0;
    bit done = 1'b0;
    logic [23:0] exp_q[$];
    logic [23:0] last_loaded = '0;

    always #2  clk_bus = ~clk_bus;
    always #15 clk_rtc = ~clk_rtc;

    upd_bridge dut (
        .clk_bus   (clk_bus),
        .rst_bus_n (rst_bus_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .upd_ack_o (upd_ack_o),
        .clk_rtc   (clk_rtc),
        .rst_rtc_n (rst_rtc_n),
        .inc_value (inc_value),
        .inc_load  (inc_load)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk_bus);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk_bus);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk_bus);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_ack(input logic want);
        logic [31:0] rd;
        for (int i = 0; i < 200; i++) begin
            bus_read(2'd2, rd);
            if (rd[1] == want) break;
        end
        check_eq("R6 ack level", 32'(rd[1]), 32'(want));
    endtask

    // driver: stage a value, push expectation, run the four-phase handshake
    task automatic do_update(input logic [15:0] lo, input logic [7:0] hi);
        bus_write(2'd0, {16'h0, lo});
        bus_write(2'd1, {24'h0, hi});
        exp_q.push_back({hi, lo});
        bus_write(2'd2, 32'h1);
        wait_ack(1'b1);
        check_eq("R8 ack port high", 32'(upd_ack_o), 32'h1);
        bus_write(2'd2, 32'h0);
        wait_ack(1'b0);
        check_eq("R5 value after update", 32'(inc_value), 32'({hi, lo}));
    endtask

    // monitor: scoreboard on counter-domain load strobes
    always @(negedge clk_rtc) begin
        if (rst_rtc_n && inc_load) begin
            loads++;
            if (exp_q.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R7 unexpected load: got %h expected none", inc_value);
            end else begin
                check_eq("R5 scoreboard value", 32'(inc_value), 32'(exp_q.pop_front()));
            end
            last_loaded = inc_value;
        end
    end

    always @(posedge clk_bus) begin
        bus_cycles++;
        if (bus_cycles > 150000) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk_bus);
        rst_bus_n = 1'b1;
        rst_rtc_n = 1'b1;
        repeat (2) @(negedge clk_bus);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), rd);
            check_eq("R1 reset register", rd, 32'h0);
        end
        check_eq("R1 reset value", 32'(inc_value), 32'h0);
        check_eq("R1 reset load", 32'(inc_load), 32'h0);
        check_eq("R1 reset ack port", 32'(upd_ack_o), 32'h0);

        // R2 address map and field widths
        bus_write(2'd0, 32'h0000_BEEF);
        bus_read(2'd0, rd);
        check_eq("R2 low field", rd, 32'h0000_BEEF);
        bus_write(2'd1, 32'hFFFF_FF5A);
        bus_read(2'd1, rd);
        check_eq("R2 high field width", rd, 32'h0000_005A);
        bus_write(2'd0, 32'hFFFF_1234);
        bus_read(2'd0, rd);
        check_eq("R2 low field width", rd, 32'h0000_1234);
        bus_write(2'd3, 32'hFFFF_FFFF);
        bus_read(2'd3, rd);
        check_eq("R2 spare reads zero", rd, 32'h0);

        // R4 ack bit not writable
        bus_write(2'd2, 32'h2);
        bus_read(2'd2, rd);
        check_eq("R4 ack bit write ignored", rd, 32'h0);

        // manual update with writes during the pending window
        bus_write(2'd0, 32'h3456);
        bus_write(2'd1, 32'h12);
        exp_q.push_back(24'h123456);
        bus_write(2'd2, 32'h1);
        bus_read(2'd2, rd);
        check_eq("R4 request set", rd, 32'h1);
        check_eq("R8 ack port low while pending", 32'(upd_ack_o), 32'h0);
        bus_write(2'd0, 32'hAAAA);
        bus_read(2'd0, rd);
        check_eq("R3 low frozen", rd, 32'h3456);
        bus_write(2'd1, 32'h77);
        bus_read(2'd1, rd);
        check_eq("R3 high frozen", rd, 32'h12);
        bus_write(2'd2, 32'h0);
        bus_read(2'd2, rd);
        check_eq("R4 early clear ignored", rd[0] ? 32'h1 : 32'h0, 32'h1);
        wait_ack(1'b1);
        check_eq("R8 ack port high", 32'(upd_ack_o), 32'h1);
        check_eq("R5 captured value", 32'(inc_value), 32'h123456);

        // staging writable again once req equals ack; no reload while held
        bus_write(2'd0, 32'h9999);
        bus_read(2'd0, rd);
        check_eq("R3 low writable when settled", rd, 32'h9999);
        repeat (40) @(negedge clk_bus);
        check_eq("R7 no reload while held", 32'(inc_value), 32'h123456);
        bus_write(2'd2, 32'h0);
        wait_ack(1'b0);
        check_eq("R8 ack port low after clear", 32'(upd_ack_o), 32'h0);
        check_eq("R5 value kept after clear", 32'(inc_value), 32'h123456);

        // several patterns through the scoreboard
        do_update(16'hFFFF, 8'hFF);
        do_update(16'h0000, 8'h00);
        do_update(16'h5AA5, 8'hA5);
        do_update(16'h0001, 8'h80);

        repeat (40) @(negedge clk_bus);
        check_eq("R7 load count", 32'(loads), 32'd5);
        check_eq("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
        check_eq("R5 final value", 32'(last_loaded), 32'h800001);
        finish_run();
    end
endmodule